// File: doc/BRIEF.md
# Converter Serial Readout Controller

This block is the digital sequencer and four-wire serial port of a multichannel sampling converter. It steps through a fixed cycle: it requests a conversion from the converter core, waits for it to finish, parks the finished word in a static output shift register while the port sits idle (the low-power phase), and then hands the word to a host over chip select, serial clock, serial data in and serial data out. While the host clocks the word out, the block also collects a channel code from serial data in. That code selects the input for the next conversion.

The four port pins are brought into the system clock domain through a short synchronizer, and serial clock and chip select edges are detected there. The host decides when a new conversion starts. If it releases chip select before it has issued any serial clock rising edge, the read is treated as a peek: the block returns to sleep and the word stays intact. If it releases chip select after at least one rising edge, the read ends at once and a new conversion is launched. A conversion already under way cannot be disturbed from the port.

Top module: `srp_readout_ctrl`

## Requirements
- R1: While reset is applied and in the cycle after it is released, `conv_start` is 1, `chan_sel` is 0 and `sdo_oe` is 0. The first conversion therefore begins with no port activity.
- R2: `conv_start` is a one-cycle pulse. It is issued only after reset or when a readout that has seen a rising serial clock edge is ended. Every pulse starts exactly one conversion.
- R3: After `conv_done` the block sleeps while `cs_n` is high. During sleep `sdo_oe` is 0 and the captured result word is held unchanged for any length of time.
- R4: When `cs_n` goes low during sleep, `sdo_oe` becomes 1 and `sdo` shows the ready status value 0 until the first rising `sck` edge.
- R5: If `cs_n` returns high before the first rising `sck` edge, the block returns to sleep and issues no `conv_start`, and a later readout returns the same word. A rising `sck` edge that reaches the block in the same cycle as the `cs_n` rise counts as "before".
- R6: After the first rising `sck` edge, each falling `sck` edge puts the next result bit on `sdo`, most significant bit first. After the k-th falling edge `sdo` carries bit 23-(k-1). From the 25th falling edge onward it carries 0.
- R7: `sdi` is sampled on rising `sck` edges. The first 8 samples form the channel code, with the first sample as bit 7. `chan_sel` takes this code in the same cycle that `conv_start` rises, and never earlier.
- R8: If fewer than 8 rising edges were captured before `cs_n` rose, `chan_sel` keeps its previous value. A rising edge that coincides with the `cs_n` rise is not captured.
- R9: Raising `cs_n` after at least one rising `sck` edge ends the readout, drops `sdo_oe` to 0 and issues one `conv_start`.
- R10: While a conversion is running, `cs_n`, `sck` and `sdi` have no effect. `sdo_oe` stays 0, no extra `conv_start` is issued, `chan_sel` is unchanged, and the word read afterwards is the word that conversion delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial port chip select, active low |
| sck | input | 1 | Serial clock from the host, idle low |
| sdi | input | 1 | Serial data in (channel code), sampled on rising sck |
| sdo | output | 1 | Serial data out (status, then result bits) |
| sdo_oe | output | 1 | Output enable for the sdo pad; 0 means released (high-impedance) |
| conv_start | output | 1 | One-cycle request to the converter core to begin a conversion |
| conv_done | input | 1 | One-cycle pulse from the core marking a finished conversion |
| result_in | input | 24 | Finished result from the core, valid with conv_done |
| chan_sel | output | 8 | Registered channel select driven to the input multiplexer |

## Verification
The two events that can land in the same system clock cycle are a chip select rise and a serial clock rising edge. Both pass through synchronizers of equal depth, so the bench provokes the collision by changing `cs_n` and `sck` in the same time step. It does this in two places. The first is at the very first clock edge of a read, where the block must treat the read as a peek: it returns to sleep, starts no conversion and keeps the word. The second is on the eighth edge of a channel code, where the block must start a conversion but keep the old channel because the eighth bit is lost. Both outcomes are judged only at the ports, through the conversion-start count kept by the core stub, `chan_sel`, and a full readout afterwards.

// File: rtl/srp_pkg.sv
package srp_pkg;

  // Conversion cycle phases, in the order the block walks them.
  typedef enum logic [1:0] {
    ST_KICK  = 2'd0,  // one-cycle conversion request
    ST_CONV  = 2'd1,  // core busy, port ignored
    ST_SLEEP = 2'd2,  // word parked, pins idle
    ST_XFER  = 2'd3   // chip select low, port active
  } srp_state_e;

endpackage

// File: rtl/srp_sync_bit.sv
module srp_sync_bit #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], pin};
  end

  assign level = chain_q[STAGES-1];

endmodule

// File: rtl/srp_pin_front.sv
module srp_pin_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic sdi,
  output logic cs_low,
  output logic cs_rise,
  output logic sck_rise,
  output logic sck_fall,
  output logic sdi_s
);

  localparam int NPIN = 3;
  // Bit 2 = chip select (idles high), bit 1 = clock, bit 0 = data.
  localparam logic [NPIN-1:0] IDLE = 3'b100;

  logic [NPIN-1:0] raw;
  logic [NPIN-1:0] lvl;
  logic [1:0]      prev_q;   // previous cs / sck levels

  assign raw = {cs_n, sck, sdi};

  for (genvar g = 0; g < NPIN; g++) begin : g_sync
    srp_sync_bit #(.STAGES(STAGES), .RST_VAL(IDLE[g])) u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (raw[g]),
      .level (lvl[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE[2:1];
    else        prev_q <= lvl[2:1];
  end

  assign cs_low   = ~lvl[2];
  assign cs_rise  =  lvl[2] & ~prev_q[1];
  assign sck_rise =  lvl[1] & ~prev_q[0];
  assign sck_fall = ~lvl[1] &  prev_q[0];
  assign sdi_s    =  lvl[0];

endmodule

// File: rtl/srp_result_shifter.sv
module srp_result_shifter #(
  parameter int   W     = 24,
  parameter logic READY = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         arm,
  input  logic         shift,
  output logic         sdo_bit,
  output logic [W-1:0] held
);

  logic [W-1:0] sr_q;
  logic         cur_q;

  // Drop the bit just presented and pull zero in from the bottom.
  function automatic logic [W-1:0] advance(input logic [W-1:0] v);
    return {v[W-2:0], 1'b0};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cur_q <= READY;
    end else begin
      if (load) begin
        sr_q <= load_val;
      end else if (shift) begin
        sr_q  <= advance(sr_q);
        cur_q <= sr_q[W-1];
      end
      if (arm) cur_q <= READY;
    end
  end

  assign sdo_bit = cur_q;
  assign held    = sr_q;

endmodule

// File: rtl/srp_code_capture.sv
module srp_code_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         sample,
  input  logic         bit_in,
  output logic [W-1:0] code,
  output logic         full
);

  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     code_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic is_full(input logic [CNT_W-1:0] c);
    return c == CNT_W'(W);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      code_q <= '0;
      cnt_q  <= '0;
    end else if (sample && !is_full(cnt_q)) begin
      code_q <= {code_q[W-2:0], bit_in};
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign code = code_q;
  assign full = is_full(cnt_q);

endmodule

// File: rtl/srp_seq.sv
module srp_seq
  import srp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_low,
  input  logic cs_rise,
  input  logic sck_rise,
  input  logic sck_fall,
  input  logic conv_done,
  output logic conv_start,
  output logic conv_busy,
  output logic in_sleep,
  output logic in_xfer,
  output logic started,
  output logic load,
  output logic arm,
  output logic sample,
  output logic shift,
  output logic commit
);

  srp_state_e state_q, state_d;
  logic       started_q, started_d;

  always_comb begin
    state_d   = state_q;
    started_d = started_q;
    load      = 1'b0;
    arm       = 1'b0;
    sample    = 1'b0;
    shift     = 1'b0;
    commit    = 1'b0;
    unique case (state_q)
      ST_KICK: begin
        started_d = 1'b0;
        state_d   = ST_CONV;
      end
      ST_CONV: begin
        if (conv_done) begin
          load    = 1'b1;
          state_d = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (cs_low) begin
          arm       = 1'b1;
          started_d = 1'b0;
          state_d   = ST_XFER;
        end
      end
      ST_XFER: begin
        // Chip select release outranks any clock edge in the same cycle.
        if (cs_rise) begin
          if (started_q) begin
            commit  = 1'b1;
            state_d = ST_KICK;
          end else begin
            state_d = ST_SLEEP;
          end
        end else if (sck_rise) begin
          sample    = 1'b1;
          started_d = 1'b1;
        end else if (sck_fall && started_q) begin
          shift = 1'b1;
        end
      end
      default: state_d = ST_KICK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_KICK;
      started_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      started_q <= started_d;
    end
  end

  assign conv_start = (state_q == ST_KICK);
  assign conv_busy  = (state_q == ST_CONV);
  assign in_sleep   = (state_q == ST_SLEEP);
  assign in_xfer    = (state_q == ST_XFER);
  assign started    = started_q;

endmodule

// File: rtl/srp_readout_ctrl.sv
module srp_readout_ctrl #(
  parameter int   RES_W       = 24,
  parameter int   CODE_W      = 8,
  parameter int   SYNC_STAGES = 2,
  parameter logic READY_LEVEL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              conv_start,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  result_in,
  output logic [CODE_W-1:0] chan_sel
);

  localparam int CHAN_W = CODE_W;

  // Named internal events, also watched by the bound checker.
  logic cs_low, cs_rise_evt, sck_rise_evt, sck_fall_evt, sdi_s;
  logic conv_busy, in_sleep, in_xfer, started;
  logic load, arm, sample, shift, commit;
  logic sdo_bit;
  logic [RES_W-1:0]  held_word;
  logic [CHAN_W-1:0] code;
  logic              code_full;
  logic [CHAN_W-1:0] chan_q;

  // A complete code replaces the channel; a partial one leaves it alone.
  function automatic logic [CHAN_W-1:0] pick_chan(input logic [CHAN_W-1:0] old,
                                                  input logic [CHAN_W-1:0] fresh,
                                                  input logic              complete);
    return complete ? fresh : old;
  endfunction

  srp_pin_front #(.STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sck      (sck),
    .sdi      (sdi),
    .cs_low   (cs_low),
    .cs_rise  (cs_rise_evt),
    .sck_rise (sck_rise_evt),
    .sck_fall (sck_fall_evt),
    .sdi_s    (sdi_s)
  );

  srp_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_low     (cs_low),
    .cs_rise    (cs_rise_evt),
    .sck_rise   (sck_rise_evt),
    .sck_fall   (sck_fall_evt),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_busy  (conv_busy),
    .in_sleep   (in_sleep),
    .in_xfer    (in_xfer),
    .started    (started),
    .load       (load),
    .arm        (arm),
    .sample     (sample),
    .shift      (shift),
    .commit     (commit)
  );

  srp_result_shifter #(.W(RES_W), .READY(READY_LEVEL)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (result_in),
    .arm      (arm),
    .shift    (shift),
    .sdo_bit  (sdo_bit),
    .held     (held_word)
  );

  srp_code_capture #(.W(CHAN_W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (arm),
    .sample (sample),
    .bit_in (sdi_s),
    .code   (code),
    .full   (code_full)
  );

  // Channel register moves on the same edge that raises conv_start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      chan_q <= '0;
    else if (commit) chan_q <= pick_chan(chan_q, code, code_full);
  end

  assign chan_sel = chan_q;
  assign sdo_oe   = in_xfer;
  assign sdo      = in_xfer ? sdo_bit : 1'b0;

endmodule

// File: rtl/srp_readout_ctrl_chk.sv
module srp_readout_ctrl_chk #(
  parameter int RES_W  = 24,
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              conv_done,
  input logic [CODE_W-1:0] chan_sel,
  input logic              sdo,
  input logic              sdo_oe,
  input logic              in_xfer,
  input logic              in_sleep,
  input logic              conv_busy,
  input logic              started,
  input logic              cs_rise_evt,
  input logic              cs_low,
  input logic [RES_W-1:0]  held_word
);

  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  a_r3_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && !cs_low) |=> $stable(held_word));

  a_r4_ready_status: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !started) |-> (sdo_oe && sdo == 1'b0));

  a_r5_peek_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !started && cs_rise_evt) |=> (in_sleep && !conv_start));

  a_r9_abort_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && started && cs_rise_evt) |=> (conv_start && !sdo_oe));

  a_r7_chan_with_start: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_sel) |-> conv_start);

  a_r10_conv_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_busy && !conv_done) |=> (conv_busy && !sdo_oe));

endmodule

bind srp_readout_ctrl srp_readout_ctrl_chk #(.RES_W(RES_W), .CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .conv_start  (conv_start),
  .conv_done   (conv_done),
  .chan_sel    (chan_sel),
  .sdo         (sdo),
  .sdo_oe      (sdo_oe),
  .in_xfer     (in_xfer),
  .in_sleep    (in_sleep),
  .conv_busy   (conv_busy),
  .started     (started),
  .cs_rise_evt (cs_rise_evt),
  .cs_low      (cs_low),
  .held_word   (held_word)
);

// File: tb/srp_readout_ctrl_bench.sv
module srp_readout_ctrl_bench;

  localparam int CONV_CYC = 400;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic        sdo, sdo_oe, conv_start;
  logic        conv_done;
  logic [23:0] result_in;
  logic [7:0]  chan_sel;

  int checks = 0;
  int fails  = 0;

  // Converter core stub state
  int          n_starts;
  int          n_done;
  logic        busy;
  int          cnt;

  always #5 clk = ~clk;

  srp_readout_ctrl u_srp_readout_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .sdi        (sdi),
    .sdo        (sdo),
    .sdo_oe     (sdo_oe),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .result_in  (result_in),
    .chan_sel   (chan_sel)
  );

  function automatic logic [23:0] res_fn(input int idx);
    logic [31:0] h;
    h = (32'(idx) * 32'h9E37_79B1) ^ 32'h00A5_5C3C;
    return h[27:4];
  endfunction

  function automatic logic [31:0] exp_bits(input logic [23:0] w, input int n);
    logic [31:0] e;
    e = '0;
    for (int k = 0; k < n; k++) e = {e[30:0], (k < 24) ? w[23-k] : 1'b0};
    return e;
  endfunction

  // Behavioural converter core: finishes CONV_CYC cycles after a request.
  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= 0; conv_done <= 1'b0; n_starts <= 0; n_done <= 0;
      result_in <= '0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        busy <= 1'b1; cnt <= CONV_CYC; n_starts <= n_starts + 1;
      end else if (busy) begin
        if (cnt == 1) begin
          busy <= 1'b0; conv_done <= 1'b1; n_done <= n_done + 1;
          result_in <= res_fn(n_starts);
        end else cnt <= cnt - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_ready();
    @(negedge clk);
    while (busy || n_done != n_starts) @(negedge clk);
    wclk(8);
  endtask

  task automatic pulses(input int n, input logic [7:0] code, output logic [31:0] got);
    got = '0;
    for (int k = 0; k < n; k++) begin
      sdi = (k < 8) ? code[7-k] : 1'($urandom_range(0, 1));
      wclk(4); sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
      got = {got[30:0], sdo};
    end
  endtask

  logic [7:0]  exp_chan;
  logic [31:0] got;
  int          s0;

  initial begin
    void'($urandom(32'd4242));
    exp_chan = '0;
    wclk(3);
    rst_n = 1'b1;
    #1;
    chk("R1 conv_start after reset", 32'(conv_start), 1);
    chk("R1 chan_sel reset", 32'(chan_sel), 0);
    chk("R1 sdo_oe reset", 32'(sdo_oe), 0);
    wclk(2);
    chk("R2 single start pulse", 32'(conv_start), 0);
    wait_ready();
    chk("R2 one conversion", 32'(n_starts), 1);
    wclk(200);
    chk("R3 released while sleeping", 32'(sdo_oe), 0);

    // Peek: cs low, status, release before any edge
    cs_n = 1'b0; wclk(10);
    chk("R4 driving in xfer", 32'(sdo_oe), 1);
    chk("R4 ready status", 32'(sdo), 0);
    cs_n = 1'b1; wclk(10);
    chk("R5 back to sleep", 32'(sdo_oe), 0);
    chk("R5 no new conversion", 32'(n_starts), 1);

    // Full readout with a channel code
    cs_n = 1'b0; wclk(10);
    pulses(26, 8'h5A, got);
    chk("R6 word MSB first, zero tail", got, exp_bits(res_fn(1), 26));
    chk("R7 chan not yet applied", 32'(chan_sel), 32'(exp_chan));
    cs_n = 1'b1; wclk(10);
    exp_chan = 8'h5A;
    chk("R9 new conversion", 32'(n_starts), 2);
    chk("R9 released after abort", 32'(sdo_oe), 0);
    chk("R7 chan applied", 32'(chan_sel), 32'(exp_chan));

    // Port activity during a conversion
    cs_n = 1'b0; wclk(6);
    for (int k = 0; k < 4; k++) begin
      sdi = 1'b1; sck = 1'b1; wclk(8); sck = 1'b0; wclk(8);
      chk("R10 released during conversion", 32'(sdo_oe), 0);
    end
    cs_n = 1'b1;
    wait_ready();
    chk("R10 no extra start", 32'(n_starts), 2);
    chk("R10 chan unchanged", 32'(chan_sel), 32'(exp_chan));
    cs_n = 1'b0; wclk(10);
    pulses(24, 8'h00, got);
    chk("R10 word intact", got, exp_bits(res_fn(2), 24));
    cs_n = 1'b1; wclk(10);
    exp_chan = 8'h00;
    chk("R7 zero code applied", 32'(chan_sel), 32'(exp_chan));

    // Collision on the first edge: peek wins
    wait_ready();
    s0 = n_starts;
    cs_n = 1'b0; wclk(10);
    sck = 1'b1; cs_n = 1'b1; wclk(10); sck = 1'b0; wclk(10);
    chk("R5 coincident first edge no start", 32'(n_starts), 32'(s0));
    cs_n = 1'b0; wclk(10);
    pulses(24, 8'hC3, got);
    chk("R5 word kept after coincident peek", got, exp_bits(res_fn(s0), 24));
    cs_n = 1'b1; wclk(10);
    exp_chan = 8'hC3;
    chk("R7 chan C3", 32'(chan_sel), 32'(exp_chan));

    // Collision on the eighth edge: conversion starts, channel kept
    wait_ready();
    s0 = n_starts;
    cs_n = 1'b0; wclk(10);
    pulses(7, 8'h3C, got);
    sdi = 1'b0; wclk(4);
    sck = 1'b1; cs_n = 1'b1; wclk(10); sck = 1'b0; wclk(10);
    chk("R8 coincident 8th edge starts", 32'(n_starts), 32'(s0 + 1));
    chk("R8 coincident 8th edge chan kept", 32'(chan_sel), 32'(exp_chan));

    // Constrained random readouts
    for (int it = 0; it < 24; it++) begin
      int          nb;
      logic [7:0]  code;
      wait_ready();
      wclk($urandom_range(0, 60));
      s0   = n_starts;
      nb   = $urandom_range(0, 30);
      code = 8'($urandom);
      cs_n = 1'b0; wclk(10);
      chk("R4 status random", 32'(sdo), 0);
      pulses(nb, code, got);
      chk("R6 random bits", got, exp_bits(res_fn(s0), nb));
      cs_n = 1'b1; wclk(10);
      if (nb >= 8) exp_chan = code;
      chk("R8 random chan", 32'(chan_sel), 32'(exp_chan));
      chk("R2 random start count", 32'(n_starts), 32'(nb > 0 ? s0 + 1 : s0));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule